// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the front of an Ethernet receive path and decides, for each incoming frame, whether the frame is kept. The decision uses the 48-bit destination address, a small control word, a bank of 16 exact-match address slots and a 4096-bit multicast hash table. Software sets all of these through a write-only register port. A one-cycle strobe presents the destination address. One clock later the block returns an accept flag and a reason code. Statistics logic downstream can use the reason code to count unicast, multicast and broadcast receives separately.

Each promiscuous mode covers only its own class of address. Unicast promiscuous lets through every individual address but no group address. Multicast promiscuous lets through every group address, and that includes broadcast. When no mode, slot or hash bit claims the frame, it is dropped.

Top module: `rx_addr_filter`

## Requirements
- R1: Reset clears the control word, every slot valid bit and every hash word. With no further writes, any destination address is dropped with reason 0.
- R2: A pulse on `dstValid` produces `acceptValid` high exactly one cycle later, and the decision is taken from the configuration held at the strobe edge. In every cycle that does not follow a strobe, `accept` is 0 and `reason` is 0.
- R3: Byte k of the address sits in `dstAddr[8k+7:8k]`, and the group bit is `dstAddr[0]`. With unicast promiscuous set, every address whose group bit is clear is accepted with reason 1. The broadcast address is not accepted by this mode.
- R4: With multicast promiscuous set, every address whose group bit is set, broadcast included, is accepted with reason 2.
- R5: With broadcast accept set, the all-ones address is accepted with reason 3.
- R6: Slot i (0..15) has two registers. Its low word at register address 0x40+2i holds address bits 31:0. Its high word at 0x41+2i holds address bits 47:32 in data bits 15:0 and the valid bit in data bit 31. An address equal to a valid slot is accepted with reason 4. An invalid slot never matches.
- R7: The hash key is byte 5 (high) concatenated with byte 4 (low). It is shifted right by 4, 3, 2 or 0 for offset select 0, 1, 2 or 3, and the low 12 bits are kept. Hash bits 11:5 select table word 0..127, written at register address 0x80+word. Hash bits 4:0 select the bit in that word. A set bit accepts the frame with reason 5.
- R8: When several rules apply, the reason comes from the first one in this order: unicast promiscuous, multicast promiscuous, broadcast, exact slot, hash.
- R9: An address that satisfies no rule is dropped: `accept` is 0 and `reason` is 0 in the decision cycle.
- R10: The control word is at register address 0x00. Bit 0 is unicast promiscuous, bit 1 is multicast promiscuous, bit 2 is broadcast accept, and bits 4:3 are the offset select. The control word changes only on a write to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register word address |
| regWrData | input | 32 | Register write data |
| dstValid | input | 1 | Destination address strobe |
| dstAddr | input | 48 | Destination address, byte 0 in bits 7:0 |
| acceptValid | output | 1 | Decision valid, one cycle after the strobe |
| accept | output | 1 | Frame is accepted |
| reason | output | 3 | 0 drop, 1 unicast promiscuous, 2 multicast promiscuous, 3 broadcast, 4 exact slot, 5 hash |

## Verification
The assertions check three things on every cycle: the fixed latency from strobe to decision, the quiet outputs between strobes, and the two promiscuous modes winning whenever they apply. They also check that the control word holds between writes to it. Some behaviours can only be shown by the bench's scenarios, because each depends on what was written into storage earlier: the exact-slot match under the valid bit, the hash bit chosen for each of the four offsets, the full priority order, and the drop of unclaimed addresses. These scenarios are compared against a behavioural model on every clock.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;

  localparam int REG_AW    = 8;
  localparam int REG_DW    = 32;
  localparam int MAC_W     = 48;
  localparam int EX_BASE   = 8'h40;
  localparam int HASH_BASE = 8'h80;
  localparam int HASH_LSB  = 5;

  typedef enum logic [2:0] {
    RSN_NONE       = 3'd0,
    RSN_UC_PROMISC = 3'd1,
    RSN_MC_PROMISC = 3'd2,
    RSN_BCAST      = 3'd3,
    RSN_EXACT      = 3'd4,
    RSN_HASH       = 3'd5
  } reasonE;

  typedef struct packed {
    logic [1:0] offSel;
    logic       bcAccept;
    logic       mcPromisc;
    logic       ucPromisc;
  } ctlT;

  typedef struct packed {
    logic              ctlWr;
    logic              exLoWr;
    logic              exHiWr;
    logic              hashWr;
    logic [REG_AW-1:0] idx;
    logic [REG_DW-1:0] data;
    logic              decide;
  } strobesT;

endpackage

// File: rtl/rx_filt_regdec.sv
module rx_filt_regdec
  import rx_filt_pkg::*;
#(
  parameter int NUM_EXACT  = 16,
  parameter int HASH_WORDS = 128
) (
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWrData,
  input  logic              dstValid,
  output strobesT           strb
);

  localparam int EX_END   = EX_BASE + 2 * NUM_EXACT;
  localparam int HASH_END = HASH_BASE + HASH_WORDS;

  logic inCtl, inEx, inHash;
  int   addrI;

  always_comb begin
    addrI  = int'(regAddr);
    inCtl  = (addrI == 0);
    inEx   = (addrI >= EX_BASE) && (addrI < EX_END);
    inHash = (addrI >= HASH_BASE) && (addrI < HASH_END);

    strb        = '0;
    strb.data   = regWrData;
    strb.decide = dstValid;
    strb.ctlWr  = regWrEn && inCtl;
    strb.exLoWr = regWrEn && inEx && !regAddr[0];
    strb.exHiWr = regWrEn && inEx && regAddr[0];
    strb.hashWr = regWrEn && inHash;
    if (inEx) begin
      strb.idx = REG_AW'((addrI - EX_BASE) >> 1);
    end else if (inHash) begin
      strb.idx = REG_AW'(addrI - HASH_BASE);
    end
  end

endmodule

// File: rtl/rx_filt_match.sv
module rx_filt_match
  import rx_filt_pkg::*;
#(
  parameter int NUM_EXACT  = 16,
  parameter int HASH_WORDS = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobesT          strb,
  input  logic [MAC_W-1:0] dstAddr,
  output logic             acceptValid,
  output logic             accept,
  output reasonE           reason
);

  localparam int HW_W      = $clog2(HASH_WORDS);
  localparam int HASH_BITS = HW_W + HASH_LSB;

  ctlT              ctlReg;
  logic [MAC_W-1:0] exAddr  [NUM_EXACT];
  logic             exValid [NUM_EXACT];
  logic [31:0]      hashTbl [HASH_WORDS];

  // configuration storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg <= '0;
      for (int i = 0; i < NUM_EXACT; i++) begin
        exAddr[i]  <= '0;
        exValid[i] <= 1'b0;
      end
      for (int w = 0; w < HASH_WORDS; w++) begin
        hashTbl[w] <= '0;
      end
    end else begin
      if (strb.ctlWr) begin
        ctlReg <= ctlT'(strb.data[4:0]);
      end
      for (int i = 0; i < NUM_EXACT; i++) begin
        if (strb.idx == REG_AW'(i)) begin
          if (strb.exLoWr) begin
            exAddr[i][31:0] <= strb.data;
          end
          if (strb.exHiWr) begin
            exAddr[i][MAC_W-1:32] <= strb.data[MAC_W-33:0];
            exValid[i]            <= strb.data[31];
          end
        end
      end
      for (int w = 0; w < HASH_WORDS; w++) begin
        if (strb.hashWr && strb.idx == REG_AW'(w)) begin
          hashTbl[w] <= strb.data;
        end
      end
    end
  end

  // address classification
  logic isGroup, isBcast;
  assign isGroup = dstAddr[0];
  assign isBcast = &dstAddr;

  // exact slot compare, one comparator per slot
  logic [NUM_EXACT-1:0] exHit;
  for (genvar i = 0; i < NUM_EXACT; i++) begin : gSlot
    assign exHit[i] = exValid[i] && (exAddr[i] == dstAddr);
  end

  // hash lookup
  logic [15:0]          hashKey;
  logic [15:0]          hashShifted;
  logic [HASH_BITS-1:0] hashVal;
  logic [HW_W-1:0]      hashWord;
  logic [4:0]           hashBit;
  logic                 hashHit;

  always_comb begin
    hashKey = dstAddr[47:32];
    unique case (ctlReg.offSel)
      2'd0:    hashShifted = hashKey >> 4;
      2'd1:    hashShifted = hashKey >> 3;
      2'd2:    hashShifted = hashKey >> 2;
      default: hashShifted = hashKey;
    endcase
    hashVal  = hashShifted[HASH_BITS-1:0];
    hashWord = hashVal[HASH_BITS-1:HASH_LSB];
    hashBit  = hashVal[HASH_LSB-1:0];
    hashHit  = hashTbl[hashWord][hashBit];
  end

  // fixed priority decision
  reasonE rsnNext;
  always_comb begin
    if (ctlReg.ucPromisc && !isGroup)        rsnNext = RSN_UC_PROMISC;
    else if (ctlReg.mcPromisc && isGroup)    rsnNext = RSN_MC_PROMISC;
    else if (ctlReg.bcAccept && isBcast)     rsnNext = RSN_BCAST;
    else if (|exHit)                         rsnNext = RSN_EXACT;
    else if (hashHit)                        rsnNext = RSN_HASH;
    else                                     rsnNext = RSN_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acceptValid <= 1'b0;
      accept      <= 1'b0;
      reason      <= RSN_NONE;
    end else begin
      acceptValid <= strb.decide;
      accept      <= strb.decide && (rsnNext != RSN_NONE);
      reason      <= strb.decide ? rsnNext : RSN_NONE;
    end
  end

  AST_STROBE_TO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    strb.decide |=> acceptValid); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strb.decide |=> (!accept && reason == RSN_NONE)); // R2

  AST_UC_PROMISC_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.decide && ctlReg.ucPromisc && !dstAddr[0]) |=> (accept && reason == RSN_UC_PROMISC)); // R3

  AST_MC_PROMISC_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.decide && ctlReg.mcPromisc && dstAddr[0]) |=> (accept && reason == RSN_MC_PROMISC)); // R4

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ctlWr |=> $stable(ctlReg)); // R10

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ctlWr, strb.exLoWr, strb.exHiWr, strb.hashWr})); // R10

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_filt_pkg::*;
#(
  parameter int NUM_EXACT  = 16,
  parameter int HASH_WORDS = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWrData,
  input  logic        dstValid,
  input  logic [47:0] dstAddr,
  output logic        acceptValid,
  output logic        accept,
  output logic [2:0]  reason
);

  strobesT strb;
  reasonE  rsn;

  rx_filt_regdec #(.NUM_EXACT(NUM_EXACT), .HASH_WORDS(HASH_WORDS)) uDec (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .dstValid (dstValid),
    .strb     (strb)
  );

  rx_filt_match #(.NUM_EXACT(NUM_EXACT), .HASH_WORDS(HASH_WORDS)) uMatch (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .dstAddr    (dstAddr),
    .acceptValid(acceptValid),
    .accept     (accept),
    .reason     (rsn)
  );

  assign reason = rsn;

endmodule

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        dstValid = 1'b0;
  logic [47:0] dstAddr = '0;
  logic        acceptValid, accept;
  logic [2:0]  reason;

  int tests = 0;
  int fails = 0;

  rx_addr_filter uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .dstValid(dstValid), .dstAddr(dstAddr),
    .acceptValid(acceptValid), .accept(accept), .reason(reason)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural reference model
  bit [4:0]  mCtl;
  bit [47:0] mSlot [16];
  bit        mSlotV [16];
  bit [31:0] mHash [128];
  int        expValid = 0, expAcc = 0, expRsn = 0;

  function automatic int hashOf(bit [47:0] a, int sel);
    int key, sh;
    key = int'(a[47:32]);
    case (sel)
      0: sh = 4;
      1: sh = 3;
      2: sh = 2;
      default: sh = 0;
    endcase
    return (key >> sh) & 12'hFFF;
  endfunction

  function automatic int modelReason(bit [47:0] a);
    bit grp, bc;
    int h;
    grp = a[0];
    bc  = (a == BCAST);
    if (mCtl[0] && !grp) return 1;
    if (mCtl[1] && grp) return 2;
    if (mCtl[2] && bc) return 3;
    for (int i = 0; i < 16; i++) if (mSlotV[i] && mSlot[i] == a) return 4;
    h = hashOf(a, int'(mCtl[4:3]));
    if (mHash[h / 32][h % 32]) return 5;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCtl = '0;
      for (int i = 0; i < 16; i++) begin mSlot[i] = '0; mSlotV[i] = 1'b0; end
      for (int w = 0; w < 128; w++) mHash[w] = '0;
      expValid = 0; expAcc = 0; expRsn = 0;
    end else begin
      expValid = dstValid ? 1 : 0;
      expRsn   = dstValid ? modelReason(dstAddr) : 0;
      expAcc   = (expRsn != 0) ? 1 : 0;
      if (regWrEn) begin
        if (regAddr == 8'h00) mCtl = regWrData[4:0];
        else if (regAddr >= 8'h40 && regAddr < 8'h60) begin
          if (regAddr[0]) begin
            mSlot[(regAddr - 8'h40) / 2][47:32] = regWrData[15:0];
            mSlotV[(regAddr - 8'h40) / 2] = regWrData[31];
          end else begin
            mSlot[(regAddr - 8'h40) / 2][31:0] = regWrData;
          end
        end else if (regAddr >= 8'h80) mHash[regAddr - 8'h80] = regWrData;
      end
    end
  end

  function automatic string tagOf(int v, int r);
    if (v == 0) return "R2";
    case (r)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R9";
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      tests++;
      if (int'(acceptValid) != expValid || int'(accept) != expAcc || int'(reason) != expRsn) begin
        fails++;
        $display("FAIL %s model compare: got v=%0d a=%0d r=%0d, expected v=%0d a=%0d r=%0d",
                 tagOf(expValid, expRsn), acceptValid, accept, reason, expValid, expAcc, expRsn);
      end
    end
  end

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic setSlot(input int i, input logic [47:0] a, input bit v);
    regWrite(8'(8'h40 + 2 * i), a[31:0]);
    regWrite(8'(8'h41 + 2 * i), {v, 15'd0, a[47:32]});
  endtask

  task automatic setHashBitFor(input logic [47:0] a, input int sel);
    int h;
    h = hashOf(a, sel);
    regWrite(8'(8'h80 + h / 32), 32'(1) << (h % 32));
  endtask

  task automatic sendCheck(input logic [47:0] a, input int eAcc, input int eRsn, input string tag);
    dstValid = 1'b1; dstAddr = a;
    @(negedge clk);
    dstValid = 1'b0;
    tests++;
    if (acceptValid !== 1'b1 || int'(accept) != eAcc || int'(reason) != eRsn) begin
      fails++;
      $display("FAIL %s addr=%h: got v=%0d a=%0d r=%0d, expected v=1 a=%0d r=%0d",
               tag, a, acceptValid, accept, reason, eAcc, eRsn);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  localparam logic [47:0] UC_A = 48'h6655_4433_2210;
  localparam logic [47:0] UC_B = 48'h0102_0304_0508;
  localparam logic [47:0] MC_C = 48'hA1B2_C3D4_E5F7;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tests++;
    if (acceptValid !== 1'b0 || accept !== 1'b0 || reason !== 3'd0) begin
      fails++;
      $display("FAIL R1 reset outputs: got v=%0d a=%0d r=%0d, expected 0 0 0", acceptValid, accept, reason);
    end
    sendCheck(BCAST, 0, 0, "R1 empty config broadcast");
    sendCheck(UC_A, 0, 0, "R1 empty config unicast");
    sendCheck(MC_C, 0, 0, "R9 unmatched multicast");

    // R3 unicast promiscuous only (control bit 0, R10)
    regWrite(8'h00, 32'h01);
    sendCheck(UC_A, 1, 1, "R3 unicast accepted");
    sendCheck(MC_C, 0, 0, "R3 multicast not covered");
    sendCheck(BCAST, 0, 0, "R3 broadcast not covered");

    // R4 multicast promiscuous
    regWrite(8'h00, 32'h02);
    sendCheck(MC_C, 1, 2, "R4 multicast accepted");
    sendCheck(BCAST, 1, 2, "R4 broadcast as multicast");
    sendCheck(UC_A, 0, 0, "R4 unicast not covered");

    // R5 broadcast accept
    regWrite(8'h00, 32'h04);
    sendCheck(BCAST, 1, 3, "R5 broadcast accepted");
    sendCheck(MC_C, 0, 0, "R5 multicast not covered");

    // R6 exact slots
    regWrite(8'h00, 32'h00);
    setSlot(5, UC_A, 1'b1);
    setSlot(9, UC_B, 1'b0);
    setSlot(15, MC_C, 1'b1);
    sendCheck(UC_A, 1, 4, "R6 valid slot 5");
    sendCheck(UC_B, 0, 0, "R6 invalid slot 9");
    sendCheck(MC_C, 1, 4, "R6 last slot");
    setSlot(15, MC_C, 1'b0);
    sendCheck(MC_C, 0, 0, "R6 slot cleared");

    // R7 hash for each offset select
    for (int sel = 0; sel < 4; sel++) begin
      logic [47:0] hAddr;
      hAddr = {16'h9E37 + 16'(sel * 16'h1111), 32'h0000_0001};
      regWrite(8'h00, 32'(sel) << 3);
      for (int w = 0; w < 128; w++) regWrite(8'(8'h80 + w), 32'h0);
      setHashBitFor(hAddr, sel);
      sendCheck(hAddr, 1, 5, "R7 hash hit");
      sendCheck(hAddr ^ 48'h0010_0000_0000, 0, 0, "R7 neighbour key misses");
    end

    // R8 priority
    setHashBitFor(UC_A, 3);
    regWrite(8'h00, 32'h01 | (32'd3 << 3));
    sendCheck(UC_A, 1, 1, "R8 uc promisc over exact");
    regWrite(8'h00, 32'h06 | (32'd3 << 3));
    sendCheck(BCAST, 1, 2, "R8 mc promisc over broadcast");
    regWrite(8'h00, 32'h18);
    sendCheck(UC_A, 1, 4, "R8 exact over hash");

    // R2 back-to-back strobes and config write in strobe cycle
    dstValid = 1'b1; dstAddr = UC_A;
    regWrEn = 1'b1; regAddr = 8'h00; regWrData = 32'h01;
    @(negedge clk);
    regWrEn = 1'b0; dstAddr = UC_B;
    @(negedge clk);
    dstValid = 1'b0;
    @(negedge clk);

    // randomized traffic with random configuration
    for (int n = 0; n < 600; n++) begin
      int k;
      k = int'($urandom_range(0, 9));
      if (k == 0) regWrite(8'h00, $urandom);
      else if (k == 1) regWrite(8'(8'h80 + $urandom_range(0, 127)), $urandom);
      else if (k == 2) setSlot(int'($urandom_range(0, 15)), {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF, 1'($urandom));
      dstValid = 1'($urandom);
      case ($urandom_range(0, 3))
        0: dstAddr = BCAST;
        1: dstAddr = UC_A;
        default: dstAddr = {16'($urandom), $urandom};
      endcase
      @(negedge clk);
      dstValid = 1'b0;
    end

    // R1 reset clears programmed state
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    sendCheck(UC_A, 0, 0, "R1 slots cleared by reset");
    sendCheck(BCAST, 0, 0, "R1 control cleared by reset");

    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule